// File: doc/BRIEF.md
# Banked Serial Configuration Register

This block holds the configuration bits of a mixed-signal channel controller. A host writes it over three wires: a select line, a data line and a serial clock. While the select line is low, each rising edge of the serial clock shifts one data bit into a 16-bit shift register. When the select line rises, the word in that register is committed. Its top two bits choose one of four banks, and its lower fourteen bits replace that bank's contents. The new contents drive the outputs at once.

All four banks hold fixed defaults after power-up reset and again whenever the active-low sleep input is asserted. The shift register is also cleared in those two cases. Loads are locked out while sleep is asserted or the idle/servo input is high. Raising and lowering the idle/servo input never disturbs what is stored. Several fields are decoded to ports:
- a 3-bit equalization code, chosen from a data-field group or a servo-field group;
- three power-down enables;
- a write-gate signal whose polarity can be inverted.

The serial lines are brought into the system clock through two-flop synchronizers. A load controller has four states:
- LOCK: loading is disabled.
- HOLD: the select line is high, waiting for a frame.
- SHIFT: a frame is being shifted in.
- COMMIT: one cycle in which the bank is written.

Its transitions are:
- any state to LOCK when loading becomes disabled;
- LOCK to HOLD when loading is enabled and the select line is high;
- LOCK to SHIFT when loading is enabled and the select line is low;
- HOLD to SHIFT when the select line falls;
- SHIFT to COMMIT on a rising select line;
- COMMIT to HOLD.

Top module: `cfg_bank_reg`

## Requirements
- R1: While the select line is low and loading is enabled, each rising serial-clock edge shifts the data input into the LSB of a 16-bit shift register, so frames are sent MSB first.
- R2: A rising select line in the SHIFT state writes shift-register bits [13:0] into the bank addressed by bits [15:14]. It writes no other bank, and it writes at most one bank per clock.
- R3: The four banks appear on `cfg_bits`, with bank k at bits [14k+13:14k].
- R4: After reset the banks hold the defaults: bank0 0x002B, bank1 0x0000, bank2 0x1555 and bank3 0x2AAA. The shift register is cleared.
- R5: While `sleep_n` is low, every bank is held at its R4 default and the shift register is cleared. The defaults remain in place after sleep is released.
- R6: While `sleep_n` is low or `idle_srv` is high, shifting and committing are ignored. Toggling `idle_srv` leaves the banks unchanged.
- R7: Bank0 bits [2:0] hold the data-field equalization code, bits [5:3] hold the servo-field code, and bit 6 is the servo enable. `eq_code` gives the servo-field code only when bit 6 is 1 and `servo_fld` is 1; otherwise it gives the data-field code.
- R8: Bank1 bit 0 drives `pd_sync`, bit 1 drives `pd_synth` and bit 2 drives `pd_pulse`.
- R9: `wg_int` equals `wg_in` when bank0 bit 7 is 0, and equals its inverse when that bit is 1.
- R10: A frame of any length commits the last 16 bits shifted. A short frame therefore keeps the older bits of the previous frame in its upper positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| sleep_n | input | 1 | Sleep, active low; clears contents to defaults |
| idle_srv | input | 1 | High = idle (loads locked), low = servo |
| ser_sel | input | 1 | Select line: low shifts, rising edge commits |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data |
| servo_fld | input | 1 | High while inside a servo field |
| wg_in | input | 1 | Write gate from the controller |
| cfg_bits | output | 56 | All four banks, bank0 in the LSBs |
| eq_code | output | 3 | Selected equalization code |
| pd_sync | output | 1 | Synchronizer power-down |
| pd_synth | output | 1 | Synthesizer power-down |
| pd_pulse | output | 1 | Pulse detector power-down |
| wg_int | output | 1 | Write gate after polarity selection |

## Verification
Each bank drives `cfg_bits` directly, so any wrong state is visible at the ports. A wrong address decode or a wrong shift order shows up in the wrong 14-bit slice about four system clocks after the select edge. A load controller that fails to honour the lockout shows up as a bank changing during an idle or sleep interval. A wrong field decode shows up at once on `eq_code`, the power-down outputs or `wg_int`.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [1:0] {
        ST_LOCK   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_COMMIT = 2'd3
    } load_state_e;

    localparam int EQ_W        = 3;
    localparam int EQ_DATA_LSB = 0;
    localparam int EQ_SRV_LSB  = 3;
    localparam int SRV_EN_BIT  = 6;
    localparam int WG_INV_BIT  = 7;
    localparam int PD_W        = 3;

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
    import cfg_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 2,
    localparam int DATA_W = FRAME_W - ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_n,
    input  logic              idle_srv,
    input  logic              sel_s,
    input  logic              sclk_s,
    input  logic              dat_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    load_state_e        st_q, st_d;
    logic               sel_d1, sclk_d1;
    logic [FRAME_W-1:0] shreg_q;
    logic               load_ok, sel_rise, sclk_rise;

    assign load_ok   = sleep_n && !idle_srv;
    assign sel_rise  = sel_s && !sel_d1;
    assign sclk_rise = sclk_s && !sclk_d1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOCK;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOCK:   if (load_ok) st_d = sel_s ? ST_HOLD : ST_SHIFT;
            ST_HOLD:   if (!load_ok) st_d = ST_LOCK;
                       else if (!sel_s) st_d = ST_SHIFT;
            ST_SHIFT:  if (!load_ok) st_d = ST_LOCK;
                       else if (sel_rise) st_d = ST_COMMIT;
            ST_COMMIT: st_d = load_ok ? ST_HOLD : ST_LOCK;
            default:   st_d = ST_LOCK;
        endcase
    end

    // edge history and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_d1  <= 1'b1;
            sclk_d1 <= 1'b0;
            shreg_q <= '0;
        end else begin
            sel_d1  <= sel_s;
            sclk_d1 <= sclk_s;
            if (!sleep_n)
                shreg_q <= '0;
            else if (st_q == ST_SHIFT && load_ok && !sel_s && sclk_rise)
                shreg_q <= {shreg_q[FRAME_W-2:0], dat_s};
        end
    end

    // outputs
    always_comb begin
        wr_en   = (st_q == ST_COMMIT) && load_ok;
        wr_addr = shreg_q[FRAME_W-1 -: ADDR_W];
        wr_data = shreg_q[DATA_W-1:0];
    end
endmodule

// File: rtl/cfg_bank_file.sv
module cfg_bank_file #(
    parameter int NBANK  = 4,
    parameter int DATA_W = 14,
    parameter logic [NBANK*DATA_W-1:0] DEFAULTS = '0,
    localparam int ADDR_W = $clog2(NBANK)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [NBANK*DATA_W-1:0] bits
);
    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        logic [DATA_W-1:0] bank_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_q <= DEFAULTS[k*DATA_W +: DATA_W];
            else if (!sleep_n)
                bank_q <= DEFAULTS[k*DATA_W +: DATA_W];
            else if (wr_en && wr_addr == ADDR_W'(k))
                bank_q <= wr_data;
        end

        assign bits[k*DATA_W +: DATA_W] = bank_q;
    end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_pkg::*;
(
    input  logic            eq_srv_en,
    input  logic            servo_fld,
    input  logic [EQ_W-1:0] eq_dat,
    input  logic [EQ_W-1:0] eq_srv,
    input  logic            wg_inv,
    input  logic            wg_in,
    input  logic [PD_W-1:0] pd_bits,
    output logic [EQ_W-1:0] eq_code,
    output logic            pd_sync,
    output logic            pd_synth,
    output logic            pd_pulse,
    output logic            wg_int
);
    always_comb begin
        eq_code  = (eq_srv_en && servo_fld) ? eq_srv : eq_dat;
        wg_int   = wg_in ^ wg_inv;
        pd_sync  = pd_bits[0];
        pd_synth = pd_bits[1];
        pd_pulse = pd_bits[2];
    end
endmodule

// File: rtl/cfg_bank_reg.sv
module cfg_bank_reg
    import cfg_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 2,
    localparam int NBANK  = 1 << ADDR_W,
    localparam int DATA_W = FRAME_W - ADDR_W,
    parameter logic [NBANK*DATA_W-1:0] DEFAULTS =
        {14'h2AAA, 14'h1555, 14'h0000, 14'h002B}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_n,
    input  logic                    idle_srv,
    input  logic                    ser_sel,
    input  logic                    ser_clk,
    input  logic                    ser_dat,
    input  logic                    servo_fld,
    input  logic                    wg_in,
    output logic [NBANK*DATA_W-1:0] cfg_bits,
    output logic [EQ_W-1:0]         eq_code,
    output logic                    pd_sync,
    output logic                    pd_synth,
    output logic                    pd_pulse,
    output logic                    wg_int
);
    logic [2:0]        ser_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    cfg_sync2 #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_sel, ser_clk, ser_dat}),
        .q     (ser_s)
    );

    cfg_load_fsm #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_n  (sleep_n),
        .idle_srv (idle_srv),
        .sel_s    (ser_s[2]),
        .sclk_s   (ser_s[1]),
        .dat_s    (ser_s[0]),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    cfg_bank_file #(.NBANK(NBANK), .DATA_W(DATA_W), .DEFAULTS(DEFAULTS)) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_n (sleep_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bits    (cfg_bits)
    );

    cfg_decode u_dec (
        .eq_srv_en (cfg_bits[SRV_EN_BIT]),
        .servo_fld (servo_fld),
        .eq_dat    (cfg_bits[EQ_DATA_LSB +: EQ_W]),
        .eq_srv    (cfg_bits[EQ_SRV_LSB +: EQ_W]),
        .wg_inv    (cfg_bits[WG_INV_BIT]),
        .wg_in     (wg_in),
        .pd_bits   (cfg_bits[DATA_W +: PD_W]),
        .eq_code   (eq_code),
        .pd_sync   (pd_sync),
        .pd_synth  (pd_synth),
        .pd_pulse  (pd_pulse),
        .wg_int    (wg_int)
    );
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
    parameter int NBANK  = 4,
    parameter int DATA_W = 14,
    parameter logic [NBANK*DATA_W-1:0] DEFAULTS = '0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sleep_n,
    input logic                    idle_srv,
    input logic                    servo_fld,
    input logic                    wg_in,
    input logic                    wg_int,
    input logic [2:0]              eq_code,
    input logic [NBANK*DATA_W-1:0] cfg_bits
);
    logic [NBANK*DATA_W-1:0] prev_q;
    logic [NBANK-1:0]        chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= DEFAULTS;
        else        prev_q <= cfg_bits;
    end

    for (genvar k = 0; k < NBANK; k++) begin : g_chg
        assign chg[k] = cfg_bits[k*DATA_W +: DATA_W] != prev_q[k*DATA_W +: DATA_W];
    end

    p_single_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep_n) |-> $countones(chg) <= 1);

    p_sleep_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> cfg_bits == DEFAULTS);

    p_idle_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_n && idle_srv) |=> $stable(cfg_bits));

    p_data_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bits[6] || !servo_fld) |-> eq_code == cfg_bits[2:0]);

    p_servo_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[6] && servo_fld) |-> eq_code == cfg_bits[5:3]);

    p_wg_polarity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wg_int == wg_in) == !cfg_bits[7]);
endmodule

bind cfg_bank_reg cfg_bank_chk #(.NBANK(NBANK), .DATA_W(DATA_W), .DEFAULTS(DEFAULTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_n   (sleep_n),
    .idle_srv  (idle_srv),
    .servo_fld (servo_fld),
    .wg_in     (wg_in),
    .wg_int    (wg_int),
    .eq_code   (eq_code),
    .cfg_bits  (cfg_bits)
);

// File: tb/sim_cfg_bank_reg.sv
module sim_cfg_bank_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0, sleep_n = 1'b1, idle_srv = 1'b0;
    logic ser_sel = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
    logic servo_fld = 1'b0, wg_in = 1'b0;
    logic [55:0] cfg_bits;
    logic [2:0]  eq_code;
    logic pd_sync, pd_synth, pd_pulse, wg_int;

    int n_run = 0, n_fail = 0;
    logic [13:0] mb [4];
    logic [15:0] sh;

    always #2 clk = ~clk;

    cfg_bank_reg u0 (.*);

    // table: frame, servo_fld, expected eq_code
    localparam logic [19:0] VEC [8] = '{
        {16'h0031, 1'b1, 3'd1}, {16'h0071, 1'b1, 3'd6},
        {16'h0071, 1'b0, 3'd1}, {16'h4005, 1'b0, 3'd1},
        {16'h8123, 1'b1, 3'd6}, {16'hFFFF, 1'b1, 3'd6},
        {16'h00EC, 1'b0, 3'd4}, {16'h00EC, 1'b1, 3'd5}};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [55:0] act, input logic [55:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [55:0] model();
        return {mb[3], mb[2], mb[1], mb[0]};
    endfunction

    task automatic model_defaults();
        mb[0] = 14'h002B; mb[1] = 14'h0000; mb[2] = 14'h1555; mb[3] = 14'h2AAA;
        sh = '0;
    endtask

    task automatic send(input logic [31:0] v, input int n, input bit acc);
        ser_sel = 1'b0;
        tick(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            tick(3);
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
            tick(3);
            if (acc) sh = {sh[14:0], v[i]};
        end
        ser_sel = 1'b1;
        tick(10);
        if (acc) mb[sh[15:14]] = sh[13:0];
    endtask

    initial begin
        #(4 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_defaults();
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R4 reset state
        check(cfg_bits == model(), "R4 defaults", cfg_bits, model());
        check(eq_code == 3'd3, "R4/R7 default eq", 56'(eq_code), 56'd3);

        // R1 R2 R3 R7: table walk
        foreach (VEC[i]) begin
            servo_fld = VEC[i][3];
            send(32'(VEC[i][19:4]), 16, 1'b1);
            check(cfg_bits == model(), "R1/R2/R3 bank contents", cfg_bits, model());
            check(eq_code == VEC[i][2:0], "R7 eq select", 56'(eq_code), 56'(VEC[i][2:0]));
            if (i == 3)
                check({pd_pulse, pd_synth, pd_sync} == 3'b101, "R8 power-down",
                      56'({pd_pulse, pd_synth, pd_sync}), 56'd5);
        end

        // R8 single enable
        send(32'h4002, 16, 1'b1);
        check({pd_pulse, pd_synth, pd_sync} == 3'b010, "R8 synth only",
              56'({pd_pulse, pd_synth, pd_sync}), 56'd2);

        // R9 polarity: bank0 bit7 currently set
        wg_in = 1'b1;
        tick(1);
        check(wg_int == 1'b0, "R9 inverted", 56'(wg_int), 56'd0);
        send(32'h0031, 16, 1'b1);
        check(wg_int == 1'b1, "R9 true polarity", 56'(wg_int), 56'd1);
        wg_in = 1'b0;
        tick(1);
        check(wg_int == 1'b0, "R9 true polarity low", 56'(wg_int), 56'd0);

        // R6 frame while idle high is ignored
        idle_srv = 1'b1;
        tick(2);
        send(32'hC000, 16, 1'b0);
        check(cfg_bits == model(), "R6 idle lockout", cfg_bits, model());
        idle_srv = 1'b0;
        tick(3);
        idle_srv = 1'b1;
        tick(3);
        idle_srv = 1'b0;
        tick(5);
        check(cfg_bits == model(), "R6 idle toggle keeps contents", cfg_bits, model());

        // R10 long frame then short frame
        send(32'h0A8ABC, 20, 1'b1);
        check(cfg_bits == model(), "R10 long frame", cfg_bits, model());
        send(32'h5, 4, 1'b1);
        check(cfg_bits == model(), "R10 short frame", cfg_bits, model());

        // R5 sleep restores defaults; R6 frames during sleep ignored
        sleep_n = 1'b0;
        tick(3);
        model_defaults();
        check(cfg_bits == model(), "R5 sleep defaults", cfg_bits, model());
        send(32'h4007, 16, 1'b0);
        check(cfg_bits == model(), "R6 sleep lockout", cfg_bits, model());
        sleep_n = 1'b1;
        tick(5);
        check(cfg_bits == model(), "R5 defaults after wake", cfg_bits, model());
        send(32'h8000, 16, 1'b1);
        check(cfg_bits == model(), "R2 load after wake", cfg_bits, model());

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule